// File: doc/BRIEF.md
# Multiplexed-Bus Pseudo-Static RAM Device Port

This block is a clocked model of the memory end of a multiplexed address/data bus. A host first places an address on the sixteen shared lines and four upper lines. It pulses the address-valid strobe low while chip select is low, then uses the same shared lines for data. The block captures the 20-bit address, holds it, and serves reads and byte-masked writes to a small internal word array. It also keeps a 16-bit mode word. That word is reached whenever both byte-lane enables are inactive, and it needs no address phase.

The bus is split into an input half, an output half and an output-enable, so that a host controller model or a pad wrapper can resolve the shared wires. All strobes are active low and are sampled on the rising clock edge. Read data is combinational from registered state. It reflects the address latched on earlier edges and is valid in the same cycle that the read strobe is low. The block is meant to be the partner of a host controller in simulation, so that the controller sees a device that checks its own behaviour.

Top module: `psram_bus_slave`

## Requirements
- R1: On each rising edge with cs_n=0 and adv_n=0, the address register loads {a_hi, adq_i} (20 bits, a_hi as bits 19:16). With the strobe held low for several cycles, the last value wins.
- R2: While adv_n=1, the held address does not change, whatever adq_i carries during the data stage.
- R3: With cs_n=0, adv_n=1, oe_n=0 and at least one of ub_n/lb_n low, adq_oe=1 and adq_o holds the addressed word. Bits 15:8 are driven only if ub_n=0 and bits 7:0 only if lb_n=0. A disabled lane reads as zero.
- R4: A rising edge with cs_n=0, adv_n=1, we_n=0, oe_n=1 and at least one of ub_n/lb_n low writes adq_i into the addressed word. Only the lanes enabled by ub_n (bits 15:8) and lb_n (bits 7:0) are written. The word index bit j is the XOR of every address bit k with k mod 4 = j.
- R5: With cs_n=0 and ub_n=lb_n=1, the mode word is accessed whatever adv_n is. we_n=0 with oe_n=1 stores adq_i on the edge. oe_n=0 drives the stored word with adq_oe=1.
- R6: After reset the mode word equals the parameter CFG_INIT (default 16'h0A15), every array word is zero, and the held address is zero.
- R7: Writing the mode word, including bits 15:8, leaves every array word and every normal read unchanged.
- R8: adq_oe is 0 whenever cs_n=1 or oe_n=1, and also during a normal read while adv_n=0.
- R9: With cs_n=1, no edge changes the held address, the array or the mode word, whatever the other strobes do.
- R10: With oe_n=0 and we_n=0 together, the block reads and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ub_n | input | 1 | Upper byte-lane enable, active low |
| lb_n | input | 1 | Lower byte-lane enable, active low |
| a_hi | input | 4 | Upper address bits 19:16 |
| adq_i | input | 16 | Shared address/data lines as seen by the device |
| adq_o | output | 16 | Value driven onto the shared lines |
| adq_oe | output | 1 | Drive enable for the shared lines |

## Verification
A wrong held address shows up as the wrong word at the next read strobe, one cycle after the address stage. Because the word index folds all twenty address bits, corruption of the upper lines is visible as well. A lost or stray write in the array or the mode word stays hidden until that location is read back. The bench therefore reads every touched word after each scenario. A wrong drive enable appears in the very cycle it happens, because the output and its enable are compared on every clock.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int BUS_W  = 16;
    localparam int HI_W   = 4;
    localparam int ADDR_W = BUS_W + HI_W;
    localparam int LANES  = BUS_W / 8;

    // Decoded intent of one sampled set of strobes.
    typedef struct packed {
        logic latch;    // address stage
        logic wr_norm;  // array write
        logic wr_cfg;   // mode word write
        logic rd_norm;  // array read
        logic rd_cfg;   // mode word read
    } bus_op_t;

    function automatic bus_op_t decode_op(
        input logic cs_n,
        input logic adv_n,
        input logic oe_n,
        input logic we_n,
        input logic ub_n,
        input logic lb_n
    );
        bus_op_t op;
        logic    sel;
        logic    cfg_path;
        sel        = !cs_n;
        cfg_path   = ub_n && lb_n;
        op.latch   = sel && !adv_n;
        op.wr_norm = sel && adv_n && !we_n && oe_n && !cfg_path;
        op.wr_cfg  = sel && !we_n && oe_n && cfg_path;
        op.rd_norm = sel && adv_n && !oe_n && we_n && !cfg_path;
        op.rd_cfg  = sel && !oe_n && we_n && cfg_path;
        return op;
    endfunction

endpackage

// File: rtl/psram_addr_latch.sv
module psram_addr_latch #(
    parameter int BUS_W = 16,
    parameter int HI_W  = 4,
    localparam int AW   = BUS_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [BUS_W-1:0] bus,
    input  logic [HI_W-1:0]  hi,
    output logic [AW-1:0]    addr_q
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } lat_state_t;

    lat_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (capture) begin
            state_d.addr = {hi, bus};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_q = state_q.addr;

    // R1: a strobe-low edge loads the full bus plus upper lines
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (addr_q == $past({hi, bus})));

endmodule

// File: rtl/psram_word_array.sv
module psram_word_array #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    localparam int LANES = DATA_W / 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } arr_state_t;

    arr_state_t state_d, state_q;
    logic [DATA_W-1:0] merged;

    // Per-lane merge of new and old data.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_en[g] ? wdata[g*8 +: 8]
                                             : state_q.mem[idx][g*8 +: 8];
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.mem[idx] = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.mem[idx];

    // R4: a write with no lane enabled must not be requested
    p_lane_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (lane_en != '0));

endmodule

// File: rtl/psram_cfg_reg.sv
module psram_cfg_reg #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] word;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.word = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.word <= INIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.word;

    // R5: a stored word appears on the next cycle
    p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));

endmodule

// File: rtl/psram_bus_slave.sv
module psram_bus_slave #(
    parameter int           IDX_W    = 4,
    parameter logic [15:0]  CFG_INIT = 16'h0A15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        adv_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        ub_n,
    input  logic        lb_n,
    input  logic [3:0]  a_hi,
    input  logic [15:0] adq_i,
    output logic [15:0] adq_o,
    output logic        adq_oe
);
    import psram_pkg::*;

    localparam int LANE_CNT = LANES;

    bus_op_t                 op;
    logic [ADDR_W-1:0]       addr_q;
    logic [IDX_W-1:0]        idx;
    logic [LANE_CNT-1:0]     lane_en;
    logic [BUS_W-1:0]        arr_rdata;
    logic [BUS_W-1:0]        cfg_q;
    logic [BUS_W-1:0]        lane_mask;

    always_comb begin
        op = decode_op(cs_n, adv_n, oe_n, we_n, ub_n, lb_n);
    end

    assign lane_en = {~ub_n, ~lb_n};

    // Fold every held address bit into the word index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            idx[k % IDX_W] = idx[k % IDX_W] ^ addr_q[k];
        end
    end

    for (genvar g = 0; g < LANE_CNT; g++) begin : g_mask
        assign lane_mask[g*8 +: 8] = {8{lane_en[g]}};
    end

    psram_addr_latch #(
        .BUS_W (BUS_W),
        .HI_W  (HI_W)
    ) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (op.latch),
        .bus     (adq_i),
        .hi      (a_hi),
        .addr_q  (addr_q)
    );

    psram_word_array #(
        .DATA_W (BUS_W),
        .IDX_W  (IDX_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op.wr_norm),
        .lane_en (lane_en),
        .idx     (idx),
        .wdata   (adq_i),
        .rdata   (arr_rdata)
    );

    psram_cfg_reg #(
        .W    (BUS_W),
        .INIT (CFG_INIT)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (op.wr_cfg),
        .wdata (adq_i),
        .q     (cfg_q)
    );

    always_comb begin
        adq_oe = op.rd_norm || op.rd_cfg;
        adq_o  = '0;
        if (op.rd_cfg) begin
            adq_o = cfg_q;
        end else if (op.rd_norm) begin
            adq_o = arr_rdata & lane_mask;
        end
    end

    // R2: with the strobe high the held address holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_n |=> $stable(u_lat.addr_q));

    // R8: no drive without select and read strobe
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adq_oe |-> (!cs_n && !oe_n));

    // R9: a deselected edge touches no storage
    p_ignore_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(u_arr.state_q));
    p_ignore_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(cfg_q));

    // R7: mode-word path leaves the array alone
    p_cfg_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ub_n && lb_n) |=> $stable(u_arr.state_q));

    // R10: both strobes low changes nothing
    p_both_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !we_n) |=> ($stable(u_arr.state_q) && $stable(cfg_q)));

endmodule

// File: tb/psram_bus_slave_tb_top.sv
module psram_bus_slave_tb_top;

    localparam logic [15:0] CFG_DEF = 16'h0A15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, adv_n, oe_n, we_n, ub_n, lb_n;
    logic [3:0]  a_hi;
    logic [15:0] adq_i;
    logic [15:0] adq_o;
    logic        adq_oe;

    always #2 clk = ~clk;

    psram_bus_slave dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .adv_n  (adv_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .ub_n   (ub_n),
        .lb_n   (lb_n),
        .a_hi   (a_hi),
        .adq_i  (adq_i),
        .adq_o  (adq_o),
        .adq_oe (adq_oe)
    );

    // Behavioural reference state.
    logic [15:0] m_mem [16];
    logic [15:0] m_cfg;
    logic [19:0] m_addr;

    int    checks = 0;
    int    fails  = 0;
    string req    = "R6";
    bit    done   = 0;

    function automatic int fold_idx(input logic [19:0] a);
        int r = 0;
        for (int k = 0; k < 20; k++) begin
            if (a[k]) r = r ^ (1 << (k % 4));
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive, compare, then update the reference on the edge.
    task automatic step(input logic cs, input logic adv, input logic oe, input logic we,
                        input logic ub, input logic lb, input logic [15:0] bus,
                        input logic [3:0] hi);
        logic        cfg_path;
        logic        e_oe;
        logic [15:0] e_d;
        logic [15:0] mask;
        @(negedge clk);
        cs_n = cs; adv_n = adv; oe_n = oe; we_n = we; ub_n = ub; lb_n = lb;
        adq_i = bus; a_hi = hi;
        #1;
        cfg_path = ub && lb;
        mask = {{8{~ub}}, {8{~lb}}};
        e_oe = !cs && !oe && we && (cfg_path || adv);
        e_d  = cfg_path ? m_cfg : (m_mem[fold_idx(m_addr)] & mask);
        check(req, {31'd0, adq_oe}, {31'd0, e_oe});
        if (e_oe) check(req, {16'd0, adq_o}, {16'd0, e_d});
        @(posedge clk);
        if (!cs) begin
            if (!we && oe) begin
                if (cfg_path) m_cfg = bus;
                else if (adv) begin
                    if (!ub) m_mem[fold_idx(m_addr)][15:8] = bus[15:8];
                    if (!lb) m_mem[fold_idx(m_addr)][7:0]  = bus[7:0];
                end
            end
            if (!adv) m_addr = {hi, bus};
        end
    endtask

    task automatic latch(input logic [19:0] a);
        step(0, 0, 1, 1, 0, 0, a[15:0], a[19:16]);
    endtask
    task automatic wr_word(input logic [19:0] a, input logic [15:0] d,
                           input logic ub, input logic lb);
        latch(a);
        step(0, 1, 1, 0, ub, lb, d, 4'h0);
        step(1, 1, 1, 1, 1, 1, 16'h0, 4'h0);
    endtask
    task automatic rd_word(input logic [19:0] a, input logic ub, input logic lb);
        latch(a);
        step(0, 1, 0, 1, ub, lb, 16'h0, 4'h0);
        step(1, 1, 1, 1, 1, 1, 16'h0, 4'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cs_n = 1; adv_n = 1; oe_n = 1; we_n = 1; ub_n = 1; lb_n = 1;
        a_hi = 0; adq_i = 0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        m_cfg = CFG_DEF; m_addr = '0;
        repeat (3) @(posedge clk);
        #1 check("R8", {31'd0, adq_oe}, 32'd0);
        @(negedge clk); rst_n = 1;

        // R6: reset defaults
        req = "R6";
        step(0, 1, 0, 1, 1, 1, 16'h0, 4'h0);
        rd_word(20'h00000, 0, 0);
        rd_word(20'h00007, 0, 0);

        // R4 / R3: fill all words, read back in full and per lane
        req = "R4";
        for (int i = 0; i < 16; i++) wr_word(20'(i), 16'(16'h1111 * i + 16'h0203), 0, 0);
        req = "R3";
        for (int i = 0; i < 16; i++) rd_word(20'(i), 0, 0);
        rd_word(20'h00005, 1, 0);
        rd_word(20'h00009, 0, 1);
        req = "R4";
        wr_word(20'h00003, 16'hABCD, 0, 1);
        wr_word(20'h00004, 16'hEF12, 1, 0);
        rd_word(20'h00003, 0, 0);
        rd_word(20'h00004, 0, 0);

        // R1: upper lines and last-wins while strobe held low
        req = "R1";
        wr_word(20'hA0000, 16'h5A5A, 0, 0);
        rd_word(20'h0000A, 0, 0);
        step(0, 0, 1, 1, 0, 0, 16'h0001, 4'h0);
        step(0, 0, 1, 1, 0, 0, 16'h0002, 4'h3);
        step(0, 1, 0, 1, 0, 0, 16'h0000, 4'h0);
        rd_word(20'h30000, 0, 0);

        // R8: normal read with strobe low is not driven
        req = "R8";
        step(0, 0, 0, 1, 0, 0, 16'h0006, 4'h0);
        step(0, 1, 1, 1, 0, 0, 16'h0000, 4'h0);

        // R2: data-stage bus changes do not move the address
        req = "R2";
        latch(20'h00006);
        step(0, 1, 0, 1, 0, 0, 16'hFFFF, 4'hF);
        step(0, 1, 0, 1, 0, 0, 16'h0001, 4'h0);
        step(0, 1, 1, 0, 0, 0, 16'h7777, 4'h0);
        step(0, 1, 0, 1, 0, 0, 16'h0002, 4'h0);

        // R9: deselected strobes change nothing
        req = "R9";
        step(1, 0, 1, 0, 0, 0, 16'h000C, 4'h1);
        step(1, 1, 1, 0, 0, 0, 16'hDEAD, 4'h0);
        step(1, 1, 1, 0, 1, 1, 16'hBEEF, 4'h0);
        step(1, 1, 0, 1, 0, 0, 16'h0000, 4'h0);
        step(0, 1, 0, 1, 0, 0, 16'h0000, 4'h0);
        step(0, 1, 0, 1, 1, 1, 16'h0000, 4'h0);

        // R5: mode word access, with and without strobe low
        req = "R5";
        step(0, 1, 1, 0, 1, 1, 16'hC3A5, 4'h0);
        step(0, 1, 0, 1, 1, 1, 16'h0000, 4'h0);
        step(0, 0, 1, 0, 1, 1, 16'h0011, 4'h0);
        step(0, 0, 0, 1, 1, 1, 16'h0000, 4'h0);

        // R7: mode word writes do not disturb the array
        req = "R7";
        step(0, 1, 1, 0, 1, 1, 16'hFF00, 4'h0);
        for (int i = 0; i < 16; i++) rd_word(20'(i), 0, 0);

        // R10: both strobes low
        req = "R10";
        latch(20'h00002);
        step(0, 1, 0, 0, 0, 0, 16'h9999, 4'h0);
        step(0, 1, 0, 0, 1, 1, 16'h8888, 4'h0);
        step(0, 1, 0, 1, 0, 0, 16'h0000, 4'h0);
        step(0, 1, 0, 1, 1, 1, 16'h0000, 4'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule